// File: doc/BRIEF.md
# Extended Word Divide Unit

This unit performs a "divide word extended" operation. The first 32-bit operand is placed in the upper half of a 64-bit dividend whose lower half is zero. That dividend is divided by the second 32-bit operand. In signed mode the divisor is sign-extended. In unsigned mode it is zero-extended. The quotient must fit in 32 bits. When it does not, or when the divisor makes the division meaningless, the result is an overflow and the quotient output is forced to zero.

A caller pulses `start` together with the operands and three control bits:

- `signed_mode` selects signed or unsigned division.
- `ov_en` enables recording of the overflow flags.
- `rec_en` enables the update of a 4-bit condition field.

Some overflow cases are visible from the operands alone. These are caught in the start cycle and skip the divider. All other operations run a restoring shift-subtract loop that produces one quotient bit per clock. The unit then fixes the quotient sign and checks that the result fits. In every case one `done` pulse marks the cycle in which the quotient, flags and condition field are valid. The overflow flag, the sticky summary-overflow flag and the condition field hold their values between operations.

Top module: `xdiv_word_ext`

## Requirements
- R1: In unsigned mode with a nonzero divisor greater than the first operand, the quotient equals floor((A·2^32) / B), where A and B are taken as unsigned 32-bit values.
- R2: In signed mode, the quotient equals (A·2^32) / B on two's-complement values, truncated toward zero, whenever that value fits in a signed 32-bit word.
- R3: A zero divisor is an overflow in both modes, and the quotient output is then 0.
- R4: In unsigned mode, A ≥ B (unsigned compare) is an overflow, and the quotient output is 0.
- R5: In signed mode, A = 0x80000000 with B = 0xFFFFFFFF is an overflow, and the quotient output is 0.
- R6: In signed mode, a quotient outside the signed 32-bit range is an overflow, and the quotient output is 0.
- R7: With `ov_en` set, the overflow flag takes the overflow status of the operation. An overflow also sets the summary-overflow flag. A good result leaves the summary-overflow flag unchanged.
- R8: With `ov_en` clear, neither the overflow flag nor the summary-overflow flag changes.
- R9: The summary-overflow flag, once set, stays set until a synchronous reset.
- R10: With `rec_en` set, the condition field is loaded from the final 32-bit quotient, including a forced zero. The bit layout is: bit 3 = negative, bit 2 = positive and nonzero, bit 1 = zero, bit 0 = summary-overflow flag after this operation's update. With `rec_en` clear, the field keeps its value.
- R11: A `start` pulse that arrives while an operation is in progress is ignored. Each accepted operation produces exactly one single-cycle `done` pulse.
- R12: Overflow cases that are known from the operands (R3, R4, R5) raise `done` in the cycle right after the start edge. Operations that go through the divider take longer.
- R13: After reset, `done`, `quotient`, both flags and the condition field are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; taken only when idle |
| op_a | input | 32 | Operand placed in the upper dividend half |
| op_b | input | 32 | Divisor |
| signed_mode | input | 1 | 1 = signed division, 0 = unsigned |
| ov_en | input | 1 | Enable overflow-flag recording |
| rec_en | input | 1 | Enable condition-field update |
| quotient | output | 32 | Result; zero on overflow |
| done | output | 1 | One-cycle pulse when results are valid |
| ov_flag | output | 1 | Overflow flag |
| so_flag | output | 1 | Sticky summary-overflow flag |
| cond | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The unsigned patterns have three roles. Small and all-ones divisors show the exact quotient value. Equal operands and a first operand larger than the divisor separate the pre-division range check from a genuine near-limit quotient.

The signed patterns cover every sign combination, including the two most negative extremes. This separates the early most-negative-by-minus-one trap from a late fit failure with a divisor of +1, and a legal result of exactly -2^31 from one just outside the range.

Runs with flag recording and condition update switched on and off, a reset in the middle of the run, and a second start during a busy period show that the sticky flag survives good results, is cleared only by reset, and that only one operation completes per accepted start.

// File: rtl/xdw_pkg.sv
// Shared definitions for the extended word divide unit.
// Assumes: one word width drives every derived width in the unit.
package xdw_pkg;

    // Control sequencer states
    typedef enum logic [1:0] {
        XDW_IDLE = 2'd0,
        XDW_LOOP = 2'd1,
        XDW_FIX  = 2'd2
    } xdw_state_e;

    // Condition field bit positions
    localparam int unsigned CF_NEG  = 3;
    localparam int unsigned CF_POS  = 2;
    localparam int unsigned CF_ZERO = 1;
    localparam int unsigned CF_SO   = 0;

endpackage

// File: rtl/xdw_prep.sv
// Operand preparation: builds the dividend and divisor magnitudes and the
// quotient sign, and flags the overflows that are known before dividing.
// Assumes: purely combinational; the operands are valid while start is high.
module xdw_prep #(
    parameter int unsigned WORD = 32,
    localparam int unsigned DW  = 2 * WORD
) (
    input  logic [WORD-1:0] a,
    input  logic [WORD-1:0] b,
    input  logic            sgn,
    output logic [DW-1:0]   dvd_mag,
    output logic [WORD-1:0] dvs_mag,
    output logic            q_neg,
    output logic            early_ov
);

    localparam logic [WORD-1:0] MOST_NEG = {1'b1, {(WORD-1){1'b0}}};
    localparam logic [WORD-1:0] ALL_ONES = {WORD{1'b1}};

    logic            a_neg;
    logic            b_neg;
    logic [WORD-1:0] a_mag;

    // Take operand magnitudes and the sign of the quotient
    always_comb begin
        a_neg   = sgn & a[WORD-1];
        b_neg   = sgn & b[WORD-1];
        a_mag   = a_neg ? (~a + 1'b1) : a;
        dvs_mag = b_neg ? (~b + 1'b1) : b;
        dvd_mag = {a_mag, {WORD{1'b0}}};
        q_neg   = a_neg ^ b_neg;
    end

    // Detect zero divisor, unsigned range failure and most-negative by minus one
    always_comb begin
        early_ov = (b == '0)
                 | (!sgn && (a >= b))
                 | (sgn && (a == MOST_NEG) && (b == ALL_ONES));
    end

endmodule

// File: rtl/xdw_iter.sv
// Restoring shift-subtract divider. It produces one quotient bit per clock
// over DW steps. The dividend shifts out of the top of one register while
// quotient bits shift into the bottom.
// Assumes: load and step are never high together; dvs is nonzero.
module xdw_iter #(
    parameter int unsigned WORD = 32,
    localparam int unsigned DW    = 2 * WORD,
    localparam int unsigned CNT_W = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [DW-1:0]   dvd,
    input  logic [WORD-1:0] dvs,
    output logic [DW-1:0]   q_mag,
    output logic            last
);

    logic [DW-1:0]    shreg;
    logic [WORD-1:0]  rem;
    logic [WORD-1:0]  dvs_q;
    logic [CNT_W-1:0] cnt;
    logic [WORD:0]    trial;
    logic [WORD:0]    diff;
    logic             fits;

    // Form the partial remainder for this step and try the subtraction
    always_comb begin
        trial = {rem, shreg[DW-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = (trial >= {1'b0, dvs_q});
    end

    // Advance one quotient bit per clock, or reload on a new operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            rem   <= '0;
            dvs_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            shreg <= dvd;
            rem   <= '0;
            dvs_q <= dvs;
            cnt   <= '0;
        end else if (step) begin
            shreg <= {shreg[DW-2:0], fits};
            rem   <= fits ? diff[WORD-1:0] : trial[WORD-1:0];
            cnt   <= cnt + 1'b1;
        end
    end

    // Expose the quotient and flag the final step
    always_comb begin
        q_mag = shreg;
        last  = step && (cnt == CNT_W'(DW - 1));
    end

endmodule

// File: rtl/xdw_post.sv
// Result finishing: applies the quotient sign and tests whether the
// 2*WORD-bit quotient fits in one word for the selected mode.
// Assumes: purely combinational; q_mag is the complete unsigned quotient.
module xdw_post #(
    parameter int unsigned WORD = 32,
    localparam int unsigned DW  = 2 * WORD
) (
    input  logic [DW-1:0]   q_mag,
    input  logic            q_neg,
    input  logic            sgn,
    output logic [WORD-1:0] res,
    output logic            late_ov
);

    logic [DW-1:0] q_full;

    // Apply the sign and check the upper half against the mode's range
    always_comb begin
        q_full = q_neg ? (~q_mag + 1'b1) : q_mag;
        res    = q_full[WORD-1:0];
        if (sgn) begin
            late_ov = (q_full[DW-1:WORD] != {WORD{q_full[WORD-1]}});
        end else begin
            late_ov = |q_full[DW-1:WORD];
        end
    end

endmodule

// File: rtl/xdw_flags.sv
// Status state: overflow flag, sticky summary-overflow flag and condition
// field, updated once per finished operation.
// Assumes: commit is high for exactly one cycle per operation.
module xdw_flags
    import xdw_pkg::*;
#(
    parameter int unsigned WORD = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic            ov,
    input  logic            ov_en,
    input  logic            rec_en,
    input  logic [WORD-1:0] res,
    output logic            ov_flag,
    output logic            so_flag,
    output logic [3:0]      cond
);

    logic       so_next;
    logic [3:0] cond_next;

    // Work out the summary flag after this operation and the new condition field
    always_comb begin
        so_next             = ov_en ? (so_flag | ov) : so_flag;
        cond_next           = '0;
        cond_next[CF_NEG]   = res[WORD-1];
        cond_next[CF_POS]   = !res[WORD-1] && (res != '0);
        cond_next[CF_ZERO]  = (res == '0);
        cond_next[CF_SO]    = so_next;
    end

    // Update the recorded state when an operation completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_flag <= 1'b0;
            so_flag <= 1'b0;
            cond    <= '0;
        end else if (commit) begin
            if (ov_en) begin
                ov_flag <= ov;
                so_flag <= so_next;
            end
            if (rec_en) begin
                cond <= cond_next;
            end
        end
    end

endmodule

// File: rtl/xdiv_word_ext.sv
// Extended word divider top. It sequences preparation, the bit-serial loop
// and finishing, forces an overflowed quotient to zero and drives done.
// Assumes: a start while busy is dropped; done is one cycle wide.
module xdiv_word_ext
    import xdw_pkg::*;
#(
    parameter int unsigned WORD = 32,
    localparam int unsigned DW  = 2 * WORD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WORD-1:0] op_a,
    input  logic [WORD-1:0] op_b,
    input  logic            signed_mode,
    input  logic            ov_en,
    input  logic            rec_en,
    output logic [WORD-1:0] quotient,
    output logic            done,
    output logic            ov_flag,
    output logic            so_flag,
    output logic [3:0]      cond
);

    xdw_state_e      st;
    logic            busy;
    logic            accept;
    logic [DW-1:0]   dvd_mag;
    logic [WORD-1:0] dvs_mag;
    logic            q_neg;
    logic            early_ov;
    logic [DW-1:0]   q_mag;
    logic            last;
    logic [WORD-1:0] post_res;
    logic            late_ov;
    logic            sgn_q;
    logic            neg_q;
    logic            oven_q;
    logic            rec_q;
    logic            commit;
    logic            commit_ov;
    logic            commit_oven;
    logic            commit_rec;
    logic [WORD-1:0] commit_res;

    xdw_prep #(.WORD(WORD)) u_prep (
        .a        (op_a),
        .b        (op_b),
        .sgn      (signed_mode),
        .dvd_mag  (dvd_mag),
        .dvs_mag  (dvs_mag),
        .q_neg    (q_neg),
        .early_ov (early_ov)
    );

    xdw_iter #(.WORD(WORD)) u_iter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept && !early_ov),
        .step  (st == XDW_LOOP),
        .dvd   (dvd_mag),
        .dvs   (dvs_mag),
        .q_mag (q_mag),
        .last  (last)
    );

    xdw_post #(.WORD(WORD)) u_post (
        .q_mag   (q_mag),
        .q_neg   (neg_q),
        .sgn     (sgn_q),
        .res     (post_res),
        .late_ov (late_ov)
    );

    // Decide whether a start is taken and what the finishing cycle commits
    always_comb begin
        busy        = (st != XDW_IDLE);
        accept      = start && !busy;
        commit      = (accept && early_ov) || (st == XDW_FIX);
        commit_ov   = busy ? late_ov : 1'b1;
        commit_oven = busy ? oven_q  : ov_en;
        commit_rec  = busy ? rec_q   : rec_en;
        commit_res  = commit_ov ? '0 : post_res;
    end

    // Step the sequencer and hold the controls of the operation in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= XDW_IDLE;
            sgn_q  <= 1'b0;
            neg_q  <= 1'b0;
            oven_q <= 1'b0;
            rec_q  <= 1'b0;
        end else begin
            case (st)
                XDW_IDLE: begin
                    if (accept && !early_ov) begin
                        st     <= XDW_LOOP;
                        sgn_q  <= signed_mode;
                        neg_q  <= q_neg;
                        oven_q <= ov_en;
                        rec_q  <= rec_en;
                    end
                end
                XDW_LOOP: begin
                    if (last) begin
                        st <= XDW_FIX;
                    end
                end
                default: begin
                    st <= XDW_IDLE;
                end
            endcase
        end
    end

    // Register the visible quotient and the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient <= '0;
            done     <= 1'b0;
        end else begin
            done <= commit;
            if (commit) begin
                quotient <= commit_res;
            end
        end
    end

    xdw_flags #(.WORD(WORD)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .ov      (commit_ov),
        .ov_en   (commit_oven),
        .rec_en  (commit_rec),
        .res     (commit_res),
        .ov_flag (ov_flag),
        .so_flag (so_flag),
        .cond    (cond)
    );

endmodule

// File: rtl/xdw_chk.sv
// Property checker for the extended word divider. It captures the controls
// of each accepted operation and checks the outputs when done rises.
// Assumes: bound to xdiv_word_ext; busy is the top's in-progress signal.
module xdw_chk #(
    parameter int unsigned WORD = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic [WORD-1:0] op_b,
    input logic            ov_en,
    input logic            rec_en,
    input logic            done,
    input logic [WORD-1:0] quotient,
    input logic            ov_flag,
    input logic            so_flag,
    input logic [3:0]      cond
);

    logic cap_oven;
    logic cap_rec;
    logic cap_zero;

    // Remember the controls of the operation that was last accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_oven <= 1'b0;
            cap_rec  <= 1'b0;
            cap_zero <= 1'b0;
        end else if (start && !busy) begin
            cap_oven <= ov_en;
            cap_rec  <= rec_en;
            cap_zero <= (op_b == '0);
        end
    end

    // R3
    zero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && cap_zero |-> quotient == '0);

    // R6
    ov_result_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && cap_oven && ov_flag |-> quotient == '0);

    // R9
    so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_flag |=> so_flag);

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cap_oven |-> $stable(ov_flag) && $stable(so_flag));

    // R10
    cond_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && cap_rec && (quotient == '0) |-> cond[1] && (cond[0] == so_flag));

    // R11
    quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quotient) && $stable(cond) && $stable(ov_flag));

endmodule

bind xdiv_word_ext xdw_chk #(.WORD(WORD)) u_xdw_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .op_b     (op_b),
    .ov_en    (ov_en),
    .rec_en   (rec_en),
    .done     (done),
    .quotient (quotient),
    .ov_flag  (ov_flag),
    .so_flag  (so_flag),
    .cond     (cond)
);

// File: tb/xdiv_word_ext_test.sv
module xdiv_word_ext_test;

    typedef struct {
        logic [31:0] q;
        logic        ov;
        logic        so;
        logic [3:0]  cf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        signed_mode = 1'b0;
    logic        ov_en = 1'b0;
    logic        rec_en = 1'b0;
    logic [31:0] quotient;
    logic        done;
    logic        ov_flag;
    logic        so_flag;
    logic [3:0]  cond;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    exp_t sb[$];

    logic       m_ov = 1'b0;
    logic       m_so = 1'b0;
    logic [3:0] m_cf = '0;

    always #2 clk = ~clk;

    xdiv_word_ext uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .signed_mode(signed_mode), .ov_en(ov_en), .rec_en(rec_en),
        .quotient(quotient), .done(done), .ov_flag(ov_flag),
        .so_flag(so_flag), .cond(cond)
    );

    task automatic check(input bit ok, input string tag, input string got, input string want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %s expected %s", tag, got, want);
        end
    endtask

    // Monitor: pop one expected item per done pulse and compare
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(0, "R11", "extra done", "no done");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quotient == e.q && ov_flag == e.ov && so_flag == e.so && cond == e.cf,
                      e.tag,
                      $sformatf("q=%h ov=%b so=%b cf=%b", quotient, ov_flag, so_flag, cond),
                      $sformatf("q=%h ov=%b so=%b cf=%b", e.q, e.ov, e.so, e.cf));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Reference model of one operation; returns result and overflow status
    function automatic void model(input logic [31:0] a, input logic [31:0] b, input logic sg,
                                  output logic [31:0] res, output logic ov, output logic early);
        logic signed [63:0] sd, sb64, sq;
        logic [63:0] ud, uq;
        ov = 1'b0; early = 1'b0; res = '0;
        if (b == 0) begin
            ov = 1'b1; early = 1'b1;
        end else if (!sg) begin
            if (a >= b) begin
                ov = 1'b1; early = 1'b1;
            end else begin
                ud = {a, 32'h0};
                uq = ud / {32'h0, b};
                if (uq[63:32] != 0) ov = 1'b1;
                res = uq[31:0];
            end
        end else begin
            if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
                ov = 1'b1; early = 1'b1;
            end else begin
                sd = $signed({a, 32'h0});
                sb64 = {{32{b[31]}}, b};
                sq = sd / sb64;
                if (sq != {{32{sq[31]}}, sq[31:0]}) ov = 1'b1;
                res = sq[31:0];
            end
        end
        if (ov) res = '0;
    endfunction

    // Driver: compute the expected item, push it, pulse start
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sg,
                         input logic oe, input logic re, input string tag);
        exp_t e;
        logic [31:0] r;
        logic ov, early;
        model(a, b, sg, r, ov, early);
        if (oe) begin
            m_ov = ov;
            if (ov) m_so = 1'b1;
        end
        if (re) m_cf = {r[31], !r[31] && r != 0, r == 0, m_so};
        e.q = r; e.ov = m_ov; e.so = m_so; e.cf = m_cf; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        op_a = a; op_b = b; signed_mode = sg; ov_en = oe; rec_en = re; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R12: early overflow finishes one cycle after the start edge
        check(done == early, "R12", $sformatf("done=%b", done), $sformatf("done=%b", early));
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ov = 1'b0; m_so = 1'b0; m_cf = '0;
        @(negedge clk);
        // R13 reset state
        check(done == 0 && quotient == 0 && ov_flag == 0 && so_flag == 0 && cond == 0, "R13",
              $sformatf("%b %h %b %b %b", done, quotient, ov_flag, so_flag, cond), "0 0 0 0 0");
    endtask

    initial begin
        do_reset();
        // R1 unsigned quotients
        issue(32'd1, 32'd3, 0, 1, 1, "R1");
        issue(32'h1234_5678, 32'hFFFF_FFFF, 0, 1, 1, "R1");
        issue(32'd0, 32'd5, 0, 1, 1, "R1");
        issue(32'hFFFF_FFFE, 32'hFFFF_FFFF, 0, 1, 1, "R1");
        // R4 unsigned range overflow
        issue(32'd7, 32'd7, 0, 1, 1, "R4");
        issue(32'd1, 32'd3, 0, 1, 1, "R7");
        issue(32'hFFFF_FFFF, 32'd1, 0, 1, 1, "R4");
        // R3 zero divisor in both modes
        issue(32'd5, 32'd0, 0, 1, 1, "R3");
        issue(32'hFFFF_FFFF, 32'd0, 1, 1, 1, "R3");
        do_reset();
        // R2 signed quotients
        issue(32'd1, 32'd3, 1, 1, 1, "R2");
        issue(32'hFFFF_FFFF, 32'd3, 1, 1, 1, "R2");
        issue(32'hFFFF_FFFD, 32'hFFFF_FFF9, 1, 1, 1, "R2");
        issue(32'd1, 32'hFFFF_FFFE, 1, 1, 1, "R2");
        issue(32'd0, 32'hFFFF_FFFF, 1, 1, 1, "R2");
        // R5 and R6 signed overflows
        issue(32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 1, "R5");
        issue(32'h8000_0000, 32'd1, 1, 1, 1, "R6");
        issue(32'd1, 32'd1, 1, 1, 1, "R6");
        issue(32'd1, 32'hFFFF_FFFF, 1, 1, 1, "R6");
        // R7 good result clears ov, SO stays (R9)
        issue(32'd2, 32'd7, 1, 1, 1, "R9");
        // R8 recording disabled
        issue(32'd9, 32'd0, 0, 0, 1, "R8");
        issue(32'd3, 32'd4, 0, 0, 1, "R8");
        // R10 record disabled holds cond
        issue(32'hFFFF_FFFF, 32'd3, 1, 1, 0, "R10");
        issue(32'h7, 32'd0, 1, 1, 1, "R10");
        // R9 reset clears SO
        do_reset();
        // R11 start while busy is ignored
        begin
            exp_t e;
            logic [31:0] r;
            logic ov, early;
            model(32'd1, 32'd3, 0, r, ov, early);
            e.q = r; e.ov = 1'b0; e.so = 1'b0; e.cf = {r[31], !r[31] && r != 0, r == 0, 1'b0};
            e.tag = "R11";
            sb.push_back(e);
            @(negedge clk);
            op_a = 32'd1; op_b = 32'd3; signed_mode = 0; ov_en = 1; rec_en = 1; start = 1;
            @(negedge clk);
            start = 0;
            repeat (5) @(negedge clk);
            op_a = 32'd4; op_b = 32'd0; start = 1;
            @(negedge clk);
            start = 0;
            while (sb.size() != 0) @(negedge clk);
            repeat (4) @(negedge clk);
            check(so_flag == 0 && ov_flag == 0 && quotient == r, "R11",
                  $sformatf("q=%h ov=%b", quotient, ov_flag), $sformatf("q=%h ov=0", r));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule